// File: doc/BRIEF.md
# DMA Dirty Page Tracker

This block watches the write transactions a device issues toward guest memory and records which tracking pages those writes have touched, so that a live-migration flow can copy only the modified memory. Each tracking page spans 2^(12 + g) bytes. The granule exponent g is a programmable register. The block holds one state bit per tracking page for a fixed number of pages.

The results leave the block by two paths. The first is a byte-granular bitmap update path. It names the bitmap byte that holds a newly dirtied page's bit, and that byte is meant to be written to host memory as all ones. The host therefore never has to read and merge the byte. The second is a valid/ready stream that carries a page's index the first time the page goes from clean to dirty. A host-side interface clears one page or all pages, which re-arms reporting for the next migration round.

Top module: `dirty_page_tracker`

## Requirements
- R1: While tracking is enabled, a write at byte address A marks tracking page A >> (12 + g), where g is the granule exponent register. Each page owns exactly one state bit.
- R2: A write covering bytes A through A + L (wr_len = L, 0..4095) that ends in a different page from the one it starts in marks both pages. When both are newly dirtied, the starting page is reported on the stream before the ending page.
- R3: A page index appears on the report stream only when that page's bit goes from clear to set. Further writes to a page that is already dirty produce no report. A report appears on the stream in the cycle after the write is sampled.
- R4: In the cycle after the write is sampled, the bitmap path flags each newly dirtied page with byte index = page >> 3, and that byte is to be stored as 8'hFF. Lane 0 carries the starting page and lane 1 carries the ending page. Lane 1 stays silent when lane 0 is valid and names the same byte.
- R5: A page index at or above the tracked page count is ignored. It sets the sticky out-of-range flag, and the in-range page of the same write is still marked.
- R6: When the report FIFO has no room, the report is dropped and the sticky overflow flag is set. The page's bit stays set, so later writes to that page still produce no report.
- R7: A single-page clear resets that page's bit, so the next write to the page reports it again. A clear and a write to the same page in the same cycle leave the page dirty and report it.
- R8: A global-clear request clears CLR_CHUNK bits per cycle, keeps busy high during the sweep, and pulses done exactly NUM_PAGES/CLR_CHUNK cycles after the request is sampled. The request also resets both sticky flags.
- R9: A write to the granule exponent is accepted only while tracking is disabled and is ignored while tracking is enabled. Device writes arriving while tracking is disabled mark nothing.
- R10: While the stream is valid and not accepted, its valid and data hold steady.
- R11: After reset all pages are clean, no output is valid, the flags are clear and no sweep is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trk_en | input | 1 | Tracking enable |
| gra_wr | input | 1 | Granule exponent write strobe |
| gra_val | input | GRA_W | Granule exponent value |
| wr_valid | input | 1 | Device write observed this cycle |
| wr_addr | input | ADDR_W | Write start byte address |
| wr_len | input | LEN_W | Write length in bytes minus one |
| clr_pg_valid | input | 1 | Single-page clear strobe |
| clr_pg_idx | input | IDX_W | Page to clear |
| clr_all_req | input | 1 | Global clear request |
| clr_all_busy | output | 1 | Global sweep in progress |
| clr_all_done | output | 1 | One-cycle pulse at sweep end |
| pfn_valid | output | 1 | Report stream valid |
| pfn_ready | input | 1 | Report stream ready |
| pfn_data | output | IDX_W | Reported page index |
| bm0_valid | output | 1 | Bitmap lane 0 byte write |
| bm0_byte | output | IDX_W-3 | Lane 0 bitmap byte index |
| bm1_valid | output | 1 | Bitmap lane 1 byte write |
| bm1_byte | output | IDX_W-3 | Lane 1 bitmap byte index |
| oor_flag | output | 1 | Sticky out-of-range flag |
| ovf_flag | output | 1 | Sticky report overflow flag |

## Verification
The bench targets writes that cross a page boundary. Some of these cross into the next bitmap byte and some stay in the same byte. A design that marked only the first page, or that issued duplicate byte writes, would miss reports or show spurious lane-1 activity. It also drives writes that straddle the end of the tracked range, and a clear and a write to one page in the same cycle. A faulty design would drop the valid page or lose the re-report. The bench fills the report FIFO while the stream is stalled and checks that the dropped page stays set, so that no duplicate report shows up after draining. A granule write sent while tracking is enabled must leave the page mapping unchanged, and the done pulse must fall on the exact cycle the sweep length predicts.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
   localparam int BASE_SHIFT = 12;   // smallest tracking page: 4 KiB
   localparam int MAX_LEN_W  = 12;   // a write never exceeds the smallest page
endpackage

// File: rtl/dpt_page_map.sv
module dpt_page_map #(
   parameter int ADDR_W    = 40,
   parameter int LEN_W     = 12,
   parameter int GRA_W     = 4,
   parameter int NUM_PAGES = 256,
   parameter int IDX_W     = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  len,
   input  logic [GRA_W-1:0]  gra,
   output logic [IDX_W-1:0]  idx0,
   output logic [IDX_W-1:0]  idx1,
   output logic              ok0,
   output logic              hit1,
   output logic              ok1
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_PAGES);

   logic [7:0]        shamt;
   logic [ADDR_W-1:0] last_byte;
   logic [ADDR_W-1:0] frame0;
   logic [ADDR_W-1:0] frame1;

   always_comb begin
      shamt     = 8'(dpt_pkg::BASE_SHIFT) + 8'(gra);
      last_byte = addr + ADDR_W'(len);
      frame0    = addr >> shamt;
      frame1    = last_byte >> shamt;
      hit1      = (frame1 != frame0);
      ok0       = (frame0 < LIMIT);
      ok1       = (frame1 < LIMIT);
      idx0      = frame0[IDX_W-1:0];
      idx1      = frame1[IDX_W-1:0];
   end
endmodule

// File: rtl/dpt_bitmap.sv
module dpt_bitmap #(
   parameter int NUM_PAGES = 256,
   parameter int CLR_CHUNK = 32,
   parameter int IDX_W     = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s0_v,
   input  logic [IDX_W-1:0] s0_idx,
   input  logic             s1_v,
   input  logic [IDX_W-1:0] s1_idx,
   input  logic             c_v,
   input  logic [IDX_W-1:0] c_idx,
   input  logic             sweep_req,
   output logic             new0,
   output logic             new1,
   output logic             busy,
   output logic             done
);
   localparam int NUM_CHUNKS = NUM_PAGES / CLR_CHUNK;
   localparam int CHW        = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1;
   localparam logic [CHW-1:0] LAST_CHUNK = CHW'(NUM_CHUNKS - 1);

   logic [NUM_PAGES-1:0] bits;
   logic [NUM_PAGES-1:0] sweep_mask;
   logic [NUM_PAGES-1:0] clr_mask;
   logic [NUM_PAGES-1:0] eff;
   logic [NUM_PAGES-1:0] set_mask;
   logic [CHW-1:0]       ptr;

   for (genvar g = 0; g < NUM_CHUNKS; g++) begin : g_chunk
      assign sweep_mask[g*CLR_CHUNK +: CLR_CHUNK] = {CLR_CHUNK{busy && (ptr == CHW'(g))}};
   end

   always_comb begin
      clr_mask = sweep_mask | (c_v ? (NUM_PAGES'(1) << c_idx) : '0);
      eff      = bits & ~clr_mask;
      new0     = s0_v && !eff[s0_idx];
      new1     = s1_v && !eff[s1_idx];
      set_mask = (s0_v ? (NUM_PAGES'(1) << s0_idx) : '0)
               | (s1_v ? (NUM_PAGES'(1) << s1_idx) : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits <= '0;
         busy <= 1'b0;
         ptr  <= '0;
         done <= 1'b0;
      end else begin
         bits <= eff | set_mask;
         done <= 1'b0;
         if (busy) begin
            if (ptr == LAST_CHUNK) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               ptr <= ptr + CHW'(1);
            end
         end else if (sweep_req) begin
            busy <= 1'b1;
            ptr  <= '0;
         end
      end
   end

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      s0_v |=> bits[$past(s0_idx)]);                                  // R1
   AST_NEW_ONLY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (s0_v && !c_v && !busy && bits[s0_idx]) |-> !new0);             // R3
   AST_DONE_ENDS_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(busy) && !busy));                               // R8
endmodule

// File: rtl/dpt_pfn_fifo.sv
module dpt_pfn_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push0,
   input  logic [W-1:0] d0,
   input  logic         push1,
   input  logic [W-1:0] d1,
   output logic         drop,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] rp;
   logic [AW-1:0] wp;
   logic [AW:0]   cnt;
   logic [AW:0]   free;
   logic [1:0]    n_req;
   logic          acc0;
   logic          acc1;
   logic          pop;
   logic [W-1:0]  first;

   always_comb begin
      free      = DEPTH_C - cnt;
      n_req     = 2'(push0) + 2'(push1);
      acc0      = (n_req != 2'd0) && (free >= (AW+1)'(1));
      acc1      = (n_req == 2'd2) && (free >= (AW+1)'(2));
      drop      = ((n_req != 2'd0) && !acc0) || ((n_req == 2'd2) && !acc1);
      first     = push0 ? d0 : d1;
      out_valid = (cnt != '0);
      out_data  = mem[rp];
      pop       = out_valid && out_ready;
   end

   always_ff @(posedge clk) begin
      if (acc0) mem[wp] <= first;
      if (acc1) mem[wp + AW'(1)] <= d1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp  <= '0;
         wp  <= '0;
         cnt <= '0;
      end else begin
         wp  <= wp + AW'(acc0) + AW'(acc1);
         rp  <= rp + AW'(pop);
         cnt <= cnt + (AW+1)'(acc0) + (AW+1)'(acc1) - (AW+1)'(pop);
      end
   end

   AST_PFN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R10
   AST_NO_OVERFILL: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == DEPTH_C && !pop) |=> (cnt == DEPTH_C));                    // R6
endmodule

// File: rtl/dirty_page_tracker.sv
module dirty_page_tracker #(
   parameter int ADDR_W     = 40,
   parameter int LEN_W      = 12,
   parameter int GRA_W      = 4,
   parameter int NUM_PAGES  = 256,
   parameter int CLR_CHUNK  = 32,
   parameter int FIFO_DEPTH = 4,
   parameter bit MERGE_BYTE = 1'b1,
   localparam int IDX_W     = $clog2(NUM_PAGES),
   localparam int BYTE_W    = IDX_W - 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trk_en,
   input  logic              gra_wr,
   input  logic [GRA_W-1:0]  gra_val,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LEN_W-1:0]  wr_len,
   input  logic              clr_pg_valid,
   input  logic [IDX_W-1:0]  clr_pg_idx,
   input  logic              clr_all_req,
   output logic              clr_all_busy,
   output logic              clr_all_done,
   output logic              pfn_valid,
   input  logic              pfn_ready,
   output logic [IDX_W-1:0]  pfn_data,
   output logic              bm0_valid,
   output logic [BYTE_W-1:0] bm0_byte,
   output logic              bm1_valid,
   output logic [BYTE_W-1:0] bm1_byte,
   output logic              oor_flag,
   output logic              ovf_flag
);
   if (NUM_PAGES < 16 || (1 << IDX_W) != NUM_PAGES) begin : g_bad_pages
      $error("NUM_PAGES must be a power of two of at least 16");
   end
   if (NUM_PAGES % CLR_CHUNK != 0 || NUM_PAGES / CLR_CHUNK < 2) begin : g_bad_chunk
      $error("CLR_CHUNK must divide NUM_PAGES into at least two chunks");
   end
   if (LEN_W > dpt_pkg::MAX_LEN_W) begin : g_bad_len
      $error("LEN_W too wide: a write could span more than two pages");
   end
   if ((1 << $clog2(FIFO_DEPTH)) != FIFO_DEPTH || FIFO_DEPTH < 2) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end

   logic [GRA_W-1:0] gra_q;
   logic [IDX_W-1:0] idx0;
   logic [IDX_W-1:0] idx1;
   logic             ok0;
   logic             ok1;
   logic             hit1;
   logic             act;
   logic             s0_v;
   logic             s1_v;
   logic             new0;
   logic             new1;
   logic             oor_hit;
   logic             drop;
   logic             lane1_keep;

   dpt_page_map #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .GRA_W(GRA_W),
      .NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)
   ) u_map (
      .addr(wr_addr), .len(wr_len), .gra(gra_q),
      .idx0(idx0), .idx1(idx1), .ok0(ok0), .hit1(hit1), .ok1(ok1)
   );

   always_comb begin
      act     = wr_valid && trk_en;
      s0_v    = act && ok0;
      s1_v    = act && hit1 && ok1;
      oor_hit = act && (!ok0 || (hit1 && !ok1));
   end

   dpt_bitmap #(
      .NUM_PAGES(NUM_PAGES), .CLR_CHUNK(CLR_CHUNK), .IDX_W(IDX_W)
   ) u_bits (
      .clk(clk), .rst_n(rst_n),
      .s0_v(s0_v), .s0_idx(idx0), .s1_v(s1_v), .s1_idx(idx1),
      .c_v(clr_pg_valid), .c_idx(clr_pg_idx), .sweep_req(clr_all_req),
      .new0(new0), .new1(new1), .busy(clr_all_busy), .done(clr_all_done)
   );

   dpt_pfn_fifo #(
      .W(IDX_W), .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push0(new0), .d0(idx0), .push1(new1), .d1(idx1),
      .drop(drop), .out_valid(pfn_valid), .out_ready(pfn_ready),
      .out_data(pfn_data)
   );

   if (MERGE_BYTE) begin : g_merge
      assign lane1_keep = new1 && !(new0 && (idx0[IDX_W-1:3] == idx1[IDX_W-1:3]));
   end else begin : g_nomerge
      assign lane1_keep = new1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gra_q     <= '0;
         bm0_valid <= 1'b0;
         bm0_byte  <= '0;
         bm1_valid <= 1'b0;
         bm1_byte  <= '0;
         oor_flag  <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         if (gra_wr && !trk_en) gra_q <= gra_val;
         bm0_valid <= new0;
         bm0_byte  <= idx0[IDX_W-1:3];
         bm1_valid <= lane1_keep;
         bm1_byte  <= idx1[IDX_W-1:3];
         if (clr_all_req) begin
            oor_flag <= 1'b0;
            ovf_flag <= 1'b0;
         end else begin
            if (oor_hit) oor_flag <= 1'b1;
            if (drop)    ovf_flag <= 1'b1;
         end
      end
   end

   AST_GRA_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      trk_en |=> $stable(gra_q));                                     // R9
   AST_OOR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (oor_flag && !clr_all_req) |=> oor_flag);                       // R5
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !clr_all_req) |=> ovf_flag);                       // R6
   AST_LANE1_NEEDS_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !hit1) |=> !bm1_valid);                            // R2
endmodule

// File: tb/dirty_page_tracker_test.sv
`timescale 1ns/1ps
module dirty_page_tracker_test;
   localparam int NP    = 256;
   localparam int DEPTH = 4;
   localparam int NCHK  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trk_en = 1'b0;
   logic        gra_wr = 1'b0;
   logic [3:0]  gra_val = '0;
   logic        wr_valid = 1'b0;
   logic [39:0] wr_addr = '0;
   logic [11:0] wr_len = '0;
   logic        clr_pg_valid = 1'b0;
   logic [7:0]  clr_pg_idx = '0;
   logic        clr_all_req = 1'b0;
   logic        clr_all_busy, clr_all_done, pfn_valid, bm0_valid, bm1_valid;
   logic        pfn_ready = 1'b1;
   logic [7:0]  pfn_data;
   logic [4:0]  bm0_byte, bm1_byte;
   logic        oor_flag, ovf_flag;

   always #2.5 clk = ~clk;

   dirty_page_tracker uut (
      .clk(clk), .rst_n(rst_n), .trk_en(trk_en), .gra_wr(gra_wr), .gra_val(gra_val),
      .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_len(wr_len),
      .clr_pg_valid(clr_pg_valid), .clr_pg_idx(clr_pg_idx), .clr_all_req(clr_all_req),
      .clr_all_busy(clr_all_busy), .clr_all_done(clr_all_done),
      .pfn_valid(pfn_valid), .pfn_ready(pfn_ready), .pfn_data(pfn_data),
      .bm0_valid(bm0_valid), .bm0_byte(bm0_byte), .bm1_valid(bm1_valid), .bm1_byte(bm1_byte),
      .oor_flag(oor_flag), .ovf_flag(ovf_flag)
   );

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  ref_bits [NP];
   int  exp_q [$];
   int  gra_ref = 0;
   bit  trk_ref = 0;
   bit  oor_ref = 0;
   bit  ovf_ref = 0;
   bit  finished = 0;

   function automatic void check_eq(string req, string what, longint act, longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endfunction

   function automatic void push_exp(int p);
      if (exp_q.size() < DEPTH) exp_q.push_back(p);
      else ovf_ref = 1;
   endfunction

   // scoreboard monitor: pops expected reports as the stream delivers them
   always @(negedge clk) begin
      if (rst_n && pfn_valid && pfn_ready) begin
         if (exp_q.size() == 0) check_eq("R3", "unexpected report", pfn_data, -1);
         else check_eq("R3", "report order/value", pfn_data, exp_q.pop_front());
      end
   end

   task automatic do_wr(input longint a, input int len, input string tag);
      longint f0, f1;
      bit n0, n1, l1;
      int sh;
      sh = 12 + gra_ref;
      f0 = a >> sh;
      f1 = (a + len) >> sh;
      n0 = 0; n1 = 0;
      if (trk_ref) begin
         if (f0 < NP && !ref_bits[f0]) begin n0 = 1; ref_bits[f0] = 1; end
         if (f1 != f0 && f1 < NP && !ref_bits[f1]) begin n1 = 1; ref_bits[f1] = 1; end
         if (f0 >= NP || f1 >= NP) oor_ref = 1;
      end
      if (n0) push_exp(int'(f0));
      if (n1) push_exp(int'(f1));
      @(negedge clk);
      wr_valid = 1; wr_addr = 40'(a); wr_len = 12'(len);
      @(negedge clk);
      wr_valid = 0;
      l1 = n1 && !(n0 && ((f0 >> 3) == (f1 >> 3)));
      check_eq(tag, "bm0_valid", bm0_valid, n0);
      if (n0) check_eq(tag, "bm0_byte", bm0_byte, f0 >> 3);
      check_eq(tag, "bm1_valid", bm1_valid, l1);
      if (l1) check_eq(tag, "bm1_byte", bm1_byte, f1 >> 3);
      check_eq(tag, "oor_flag", oor_flag, oor_ref);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_gra(input int v);
      @(negedge clk);
      gra_wr = 1; gra_val = 4'(v);
      @(negedge clk);
      gra_wr = 0;
      if (!trk_ref) gra_ref = v;
   endtask

   task automatic clear_all();
      @(negedge clk);
      clr_all_req = 1;
      for (int i = 0; i < NP; i++) ref_bits[i] = 0;
      oor_ref = 0; ovf_ref = 0;
      @(negedge clk);
      clr_all_req = 0;
      check_eq("R8", "busy after request", clr_all_busy, 1);
      check_eq("R8", "oor cleared", oor_flag, 0);
      check_eq("R8", "ovf cleared", ovf_flag, 0);
      repeat (NCHK - 1) @(negedge clk);
      check_eq("R8", "done not early", clr_all_done, 0);
      @(negedge clk);
      check_eq("R8", "done pulse", clr_all_done, 1);
      check_eq("R8", "busy dropped", clr_all_busy, 0);
      @(negedge clk);
      check_eq("R8", "done one cycle", clr_all_done, 0);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      check_eq("R11", "pfn_valid", pfn_valid, 0);
      check_eq("R11", "bm0_valid", bm0_valid, 0);
      check_eq("R11", "bm1_valid", bm1_valid, 0);
      check_eq("R11", "flags", {oor_flag, ovf_flag}, 0);
      check_eq("R11", "busy/done", {clr_all_busy, clr_all_done}, 0);

      trk_en = 1; trk_ref = 1;
      do_wr(40'h3000, 15, "R1");           // page 3
      do_wr(40'h3100, 7, "R3");            // page 3 again: silent
      do_wr(40'h4FF0, 31, "R2");           // pages 4,5 same byte
      do_wr(40'h7FF8, 15, "R4");           // pages 7,8 distinct bytes
      do_wr(40'h8FF8, 15, "R2");           // 8 old, 9 new: lane 1 alone

      set_gra(2);                          // R9 ignored while enabled
      do_wr(40'h20000, 0, "R9");           // still 4 KiB pages -> 32

      do_wr(40'h100000, 0, "R5");          // page 256 out of range
      do_wr(40'hFFFF0, 31, "R5");          // 255 valid, 256 out of range

      // R7 single clear then rewrite
      @(negedge clk); clr_pg_valid = 1; clr_pg_idx = 8'd3;
      @(negedge clk); clr_pg_valid = 0; ref_bits[3] = 0;
      do_wr(40'h3000, 0, "R7");
      // R7 clear and write same page same cycle
      push_exp(4);
      @(negedge clk);
      clr_pg_valid = 1; clr_pg_idx = 8'd4;
      wr_valid = 1; wr_addr = 40'h4000; wr_len = 12'd0;
      @(negedge clk);
      clr_pg_valid = 0; wr_valid = 0;
      check_eq("R7", "same-cycle clear+write bm0", bm0_valid, 1);
      repeat (3) @(negedge clk);

      clear_all();

      // R9 writes while disabled, then granule change
      trk_en = 0; trk_ref = 0;
      do_wr(40'h5000, 0, "R9");
      set_gra(2);
      trk_en = 1; trk_ref = 1;
      do_wr(40'h14000, 0, "R9");           // 16 KiB pages -> 5
      do_wr(40'h17FFF, 0, "R1");           // same 16 KiB page -> silent

      // R6 overflow with stalled stream
      @(negedge clk); pfn_ready = 0;
      for (int p = 10; p < 15; p++) do_wr(longint'(p) << 14, 0, "R6");
      check_eq("R6", "ovf_flag", ovf_flag, 1);
      check_eq("R10", "pfn_valid held", pfn_valid, 1);
      check_eq("R10", "pfn_data head", pfn_data, 10);
      repeat (3) @(negedge clk);
      check_eq("R10", "pfn_data stable", pfn_data, 10);
      do_wr(longint'(14) << 14, 0, "R6");  // dropped page still dirty
      @(negedge clk); pfn_ready = 1;
      repeat (10) @(negedge clk);
      check_eq("R6", "drained queue", exp_q.size(), 0);
      check_eq("R6", "ovf still set", ovf_flag, 1);
      clear_all();

      repeat (5) @(negedge clk);
      check_eq("R3", "no pending reports", exp_q.size(), 0);
      finished = 1;
      summary();
      $finish;
   end
endmodule